// File: doc/BRIEF.md
# Asynchronous SRAM Bank Controller

This block sits between a clocked request port and a 1M x 32 asynchronous static memory. The memory is built as two banks, each holding four byte-wide devices. A request carries a 20-bit word address, a 4-bit byte mask, a read/write flag and, for writes, a 32-bit word. The controller runs one request at a time. It splits the address into a 19-bit device address shared by all devices and a bank bit. It then pulls low only the chip enables of the selected byte lanes in the selected bank, and steps the shared write-enable and output-enable strobes through timed phases.

Each phase lasts a number of clock cycles derived at elaboration from nanosecond minimums and the clock period. The data bus is split into a driven value, a drive enable and a sampled input, so the pad-level tristate sits outside the block. Read data is registered at the end of the access phase and announced with a one-cycle strobe.

Top module: `sram_bank_ctl`

## Requirements
- R1: While reset is high and on the first cycle after it, `req_ready` is 1, every bit of `mem_ce_n` is 1, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe` and `rd_valid` are 0.
- R2: During an access, `mem_addr` equals `req_addr[18:0]` of the accepted request and does not change. Bit 19 picks bank 2 when 1 and bank 1 when 0. Chip enable bit index is bank*4 + lane, where bank 1 is 0 and lane k covers data bits 8k+7..8k. Enables of both banks are never low together.
- R3: Only the lanes whose `req_mask` bit is 1 get their enable pulled low, for reads and for writes. Lanes outside the mask keep their stored bytes on a write and return 0 from the bench memory on a read.
- R4: A write begins with N_TURN cycles in which enables are low and both strobes are high with the bus not driven. These are followed by N_WP cycles with `mem_we_n` low and `req_wdata` driven with `mem_dq_oe` = 1.
- R5: `mem_oe_n` and `mem_we_n` are never low together. `mem_dq_oe` is 1 only while `mem_we_n` is low and `mem_oe_n` has been high for at least N_TURN cycles.
- R6: A read holds the enables and `mem_oe_n` low with `mem_we_n` high for N_RD cycles. `mem_dq_in` is sampled on the last of those cycles, and `rd_valid` is 1 for exactly the next cycle, with `rd_data` holding the sampled word.
- R7: After the active phase comes a recovery phase with all enables high: N_WREC cycles after a write, N_RREC after a read. `req_ready` returns to 1 on the cycle after recovery ends.
- R8: A request presented while `req_ready` is 0 is not accepted. It starts no sequence, either then or later once it has been withdrawn.
- R9: While idle, all enables are high and the bus is not driven.
- R10: Each phase count is the ceiling of the minimum in ns divided by `CLK_NS`, at least 1. N_TURN covers the release time. N_WP is the largest of pulse width, chip-select-to-end and data setup. N_RD is the largest of address, chip-select and output-enable access. N_WREC = max(1, write cycle − N_TURN − N_WP). N_RREC = max(1, N_TURN, read cycle − N_RD).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, bit 19 = bank |
| req_wdata | input | 32 | Write word |
| req_mask | input | 4 | Byte lanes to access |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 32 | Captured read word |
| mem_addr | output | 19 | Shared device address |
| mem_ce_n | output | 8 | Active-low chip enables, index bank*4+lane |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 32 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 32 | Data sampled from memory |

## Verification
A phase counter that ends a phase early or late shows up on the next cycle as a strobe or enable edge at the wrong cycle, and `req_ready` returns at the wrong time. The bench compares every strobe, enable and drive bit at every cycle of each sequence. A wrong bank or lane decode lands bytes in the wrong device of the bench memory model. That surfaces as a wrong byte in the read that follows the write. A stale request register or a late capture shows as a wrong `rd_data` on the single cycle `rd_valid` is high.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

    localparam int WORD_AW = 20;
    localparam int DEV_AW  = 19;
    localparam int LANES   = 4;
    localparam int LANE_W  = 8;
    localparam int DATA_W  = LANES * LANE_W;
    localparam int BANKS   = 2;
    localparam int CE_W    = BANKS * LANES;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WR_PRE,
        PH_WR_PULSE,
        PH_RD_ACC,
        PH_REC
    } phase_e;

    typedef struct packed {
        logic                 wr;
        logic [WORD_AW-1:0]   addr;
        logic [DATA_W-1:0]    data;
        logic [LANES-1:0]     mask;
    } req_t;

    // ceiling of ns / period, never below one cycle
    function automatic int cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_decode.sv
`timescale 1ns/1ps
module sram_lane_decode
    import sram_ctl_pkg::*;
(
    input  logic             active,
    input  logic             bank,
    input  logic [LANES-1:0] mask,
    output logic [CE_W-1:0]  ce_n
);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam logic BSEL = 1'(b);
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign ce_n[b*LANES + l] = !(active && (bank == BSEL) && mask[l]);
        end
    end

endmodule

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer
    import sram_ctl_pkg::*;
#(
    parameter int N_TURN = 2,
    parameter int N_WP   = 5,
    parameter int N_WREC = 1,
    parameter int N_RD   = 6,
    parameter int N_RREC = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   start_wr,
    output phase_e phase,
    output logic   last
);

    localparam int MAXC  = imax(imax(imax(N_TURN, N_WP), imax(N_WREC, N_RD)), N_RREC);
    localparam int CNT_W = $clog2(MAXC + 1);

    logic [CNT_W-1:0] cnt;

    assign last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (start) begin
                    phase <= start_wr ? PH_WR_PRE : PH_RD_ACC;
                    cnt   <= start_wr ? CNT_W'(N_TURN - 1) : CNT_W'(N_RD - 1);
                end
                PH_WR_PRE: if (last) begin
                    phase <= PH_WR_PULSE;
                    cnt   <= CNT_W'(N_WP - 1);
                end else cnt <= cnt - 1'b1;
                PH_WR_PULSE: if (last) begin
                    phase <= PH_REC;
                    cnt   <= CNT_W'(N_WREC - 1);
                end else cnt <= cnt - 1'b1;
                PH_RD_ACC: if (last) begin
                    phase <= PH_REC;
                    cnt   <= CNT_W'(N_RREC - 1);
                end else cnt <= cnt - 1'b1;
                PH_REC: if (last) begin
                    phase <= PH_IDLE;
                end else cnt <= cnt - 1'b1;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) < MAXC); // R10

    AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_REC && last) |=> (phase == PH_IDLE)); // R7

endmodule

// File: rtl/sram_bank_ctl.sv
`timescale 1ns/1ps
module sram_bank_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS   = 10,
    parameter int T_WP_NS  = 40,
    parameter int T_CW_NS  = 45,
    parameter int T_DW_NS  = 25,
    parameter int T_WC_NS  = 55,
    parameter int T_AA_NS  = 55,
    parameter int T_CO_NS  = 55,
    parameter int T_OE_NS  = 25,
    parameter int T_RC_NS  = 55,
    parameter int T_HZ_NS  = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [WORD_AW-1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [LANES-1:0]   req_mask,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic [DEV_AW-1:0]  mem_addr,
    output logic [CE_W-1:0]    mem_ce_n,
    output logic               mem_we_n,
    output logic               mem_oe_n,
    output logic [DATA_W-1:0]  mem_dq_out,
    output logic               mem_dq_oe,
    input  logic [DATA_W-1:0]  mem_dq_in
);

    localparam int N_TURN = cyc(T_HZ_NS, CLK_NS);
    localparam int N_WP   = imax(imax(cyc(T_WP_NS, CLK_NS), cyc(T_CW_NS, CLK_NS)),
                                 cyc(T_DW_NS, CLK_NS));
    localparam int N_WREC = imax(1, cyc(T_WC_NS, CLK_NS) - N_TURN - N_WP);
    localparam int N_RD   = imax(imax(cyc(T_AA_NS, CLK_NS), cyc(T_CO_NS, CLK_NS)),
                                 cyc(T_OE_NS, CLK_NS));
    localparam int N_RREC = imax(imax(1, N_TURN), cyc(T_RC_NS, CLK_NS) - N_RD);

    phase_e phase;
    logic   last;
    logic   accept;
    logic   ce_active;
    req_t   req_q;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    sram_phase_timer #(
        .N_TURN (N_TURN),
        .N_WP   (N_WP),
        .N_WREC (N_WREC),
        .N_RD   (N_RD),
        .N_RREC (N_RREC)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .start_wr (req_write),
        .phase    (phase),
        .last     (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (accept) begin
            req_q <= '{wr: req_write, addr: req_addr, data: req_wdata, mask: req_mask};
        end
    end

    assign ce_active = (phase == PH_WR_PRE) || (phase == PH_WR_PULSE) || (phase == PH_RD_ACC);

    sram_lane_decode u_decode (
        .active (ce_active),
        .bank   (req_q.addr[WORD_AW-1]),
        .mask   (req_q.mask),
        .ce_n   (mem_ce_n)
    );

    assign mem_addr   = req_q.addr[DEV_AW-1:0];
    assign mem_we_n   = (phase != PH_WR_PULSE);
    assign mem_oe_n   = (phase != PH_RD_ACC);
    assign mem_dq_oe  = (phase == PH_WR_PULSE);
    assign mem_dq_out = req_q.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (phase == PH_RD_ACC) && last;
            if ((phase == PH_RD_ACC) && last) rd_data <= mem_dq_in;
        end
    end

    // run-length monitors for the strobe checks below
    logic [15:0] we_low_run;
    logic [15:0] oe_high_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_run  <= '0;
            oe_high_run <= '0;
        end else begin
            we_low_run  <= !mem_we_n ? ((we_low_run == 16'hFFFF) ? we_low_run : we_low_run + 1'b1) : '0;
            oe_high_run <= mem_oe_n ? ((oe_high_run == 16'hFFFF) ? oe_high_run : oe_high_run + 1'b1) : '0;
        end
    end

    AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!mem_oe_n && !mem_we_n)); // R5

    AST_DRIVE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n)); // R5

    AST_TURN_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (int'(oe_high_run) >= N_TURN)); // R5

    AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (int'(we_low_run) >= N_WP)); // R4

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (rst)
        (&mem_ce_n[LANES-1:0]) || (&mem_ce_n[CE_W-1:LANES])); // R2

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!(&mem_ce_n) && !$past(&mem_ce_n)) |-> $stable(mem_addr)); // R2

    AST_RDV_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R6

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> ((&mem_ce_n) && !mem_dq_oe)); // R9

endmodule

// File: tb/sram_bank_ctl_bench.sv
`timescale 1ns/1ps
module sram_bank_ctl_bench;

    localparam int CLK_PERIOD = 10;

    // phase counts from the requirement formulas (R10)
    function automatic int c_of(input int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    localparam int E_TURN = c_of(20);
    localparam int E_WP   = mx(mx(c_of(40), c_of(45)), c_of(25));
    localparam int E_WREC = mx(1, c_of(55) - E_TURN - E_WP);
    localparam int E_RD   = mx(mx(c_of(55), c_of(55)), c_of(25));
    localparam int E_RREC = mx(mx(1, E_TURN), c_of(55) - E_RD);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_mask = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [18:0] mem_addr;
    logic [7:0]  mem_ce_n;
    logic        mem_we_n;
    logic        mem_oe_n;
    logic [31:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [31:0] mem_dq_in;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_bank_ctl u_sram_bank_ctl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // pin-level memory model: 2 banks x 4 lanes x 16 words
    logic [7:0] dev [2][4][16];
    logic [7:0] shadow [2][4][16];

    always @(posedge clk) begin
        for (int l = 0; l < 4; l++) begin
            for (int b = 0; b < 2; b++) begin
                if (!mem_we_n && !mem_ce_n[b*4+l] && mem_dq_oe)
                    dev[b][l][mem_addr[3:0]] <= mem_dq_out[l*8 +: 8];
            end
        end
    end

    always_comb begin
        mem_dq_in = '0;
        for (int l = 0; l < 4; l++) begin
            if (!mem_oe_n && mem_we_n) begin
                if (!mem_ce_n[l])        mem_dq_in[l*8 +: 8] = dev[0][l][mem_addr[3:0]];
                else if (!mem_ce_n[4+l]) mem_dq_in[l*8 +: 8] = dev[1][l][mem_addr[3:0]];
            end
        end
    end

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic check_eq(input string req, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ce_of(input logic bank, input logic [3:0] m);
        return bank ? ~{m, 4'h0} : ~{4'h0, m};
    endfunction

    // {ce_n, we_n, oe_n, dq_oe, ready}
    function automatic logic [11:0] pins();
        return {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready};
    endfunction

    task automatic issue(input logic wr, input logic [19:0] a,
                         input logic [31:0] d, input logic [3:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [19:0] a, input logic [31:0] d, input logic [3:0] m);
        logic [7:0] ce;
        ce = ce_of(a[19], m);
        issue(1'b1, a, d, m);
        for (int i = 0; i < E_TURN; i++) begin
            check_eq("R4", "write turnaround pins", 64'(pins()), 64'({ce, 1'b1, 1'b1, 1'b0, 1'b0}));
            @(negedge clk);
        end
        for (int i = 0; i < E_WP; i++) begin
            check_eq("R4", "write pulse pins", 64'(pins()), 64'({ce, 1'b0, 1'b1, 1'b1, 1'b0}));
            check_eq("R2", "write address/data", {13'h0, mem_addr, mem_dq_out}, {13'h0, a[18:0], d});
            @(negedge clk);
        end
        for (int i = 0; i < E_WREC; i++) begin
            check_eq("R7", "write recovery pins", 64'(pins()), 64'({8'hFF, 1'b1, 1'b1, 1'b0, 1'b0}));
            @(negedge clk);
        end
        check_eq("R7", "ready after write", 64'(req_ready), 64'(1));
        for (int l = 0; l < 4; l++)
            if (m[l]) shadow[a[19]][l][a[3:0]] = d[l*8 +: 8];
    endtask

    task automatic do_read(input logic [19:0] a, input logic [3:0] m);
        logic [7:0]  ce;
        logic [31:0] exp;
        ce  = ce_of(a[19], m);
        exp = '0;
        for (int l = 0; l < 4; l++)
            if (m[l]) exp[l*8 +: 8] = shadow[a[19]][l][a[3:0]];
        issue(1'b0, a, 32'h0, m);
        for (int i = 0; i < E_RD; i++) begin
            check_eq("R6", "read access pins", 64'(pins()), 64'({ce, 1'b1, 1'b0, 1'b0, 1'b0}));
            check_eq("R2", "read address", 64'(mem_addr), 64'(a[18:0]));
            @(negedge clk);
        end
        for (int i = 0; i < E_RREC; i++) begin
            check_eq("R7", "read recovery pins", 64'(pins()), 64'({8'hFF, 1'b1, 1'b1, 1'b0, 1'b0}));
            if (i == 0) begin
                check_eq("R6", "rd_valid strobe", 64'(rd_valid), 64'(1));
                check_eq("R3", "read data by mask", 64'(rd_data), 64'(exp));
            end else begin
                check_eq("R6", "rd_valid single cycle", 64'(rd_valid), 64'(0));
            end
            @(negedge clk);
        end
        check_eq("R7", "ready after read", 64'({req_ready, rd_valid}), 64'(2'b10));
    endtask

    task automatic busy_probe();
        logic [7:0] ce;
        ce = ce_of(1'b0, 4'hF);
        issue(1'b1, 20'h00007, 32'hA5A5_5A5A, 4'hF);
        for (int i = 0; i < E_TURN + E_WP + E_WREC; i++) begin
            req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h80003; req_mask = 4'h3;
            check_eq("R8", "busy holds write enables", 64'(mem_ce_n == ce || mem_ce_n == 8'hFF), 64'(1));
            @(negedge clk);
        end
        req_valid = 1'b0;
        for (int l = 0; l < 4; l++) shadow[0][l][7] = 8'(32'hA5A5_5A5A >> (l*8));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check_eq("R8", "withdrawn busy request never starts", 64'(pins()), 64'({8'hFF, 1'b1, 1'b1, 1'b0, 1'b1}));
            check_eq("R9", "idle standby no strobe", 64'(rd_valid), 64'(0));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int l = 0; l < 4; l++)
                for (int w = 0; w < 16; w++) begin
                    dev[b][l][w] = 8'h00;
                    shadow[b][l][w] = 8'h00;
                end
        check_eq("R10", "turn/pulse/wrec/rd/rrec counts",
                 64'({8'(E_TURN), 8'(E_WP), 8'(E_WREC), 8'(E_RD), 8'(E_RREC)}),
                 64'({8'd2, 8'd5, 8'd1, 8'd6, 8'd2}));
        repeat (3) @(negedge clk);
        check_eq("R1", "pins in reset", 64'({pins(), rd_valid}), 64'({8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}));
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "pins after reset", 64'({pins(), rd_valid}), 64'({8'hFF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}));
        check_eq("R9", "idle standby", 64'({mem_ce_n, mem_dq_oe}), 64'({8'hFF, 1'b0}));

        // sweep: every nonzero mask in both banks, partial write then reads
        for (int b = 0; b < 2; b++) begin
            for (int m = 1; m < 16; m++) begin
                logic [19:0] a;
                logic [31:0] d;
                a = {1'(b), 15'h2D5A, 4'(m)};
                d = 32'h9E37_79B9 * 32'(m + 16*b + 1);
                do_write(a, d, 4'(m));
                do_read(a, 4'hF);
                do_read(a, 4'(m));
            end
        end
        // overwrite same words in bank 1 and partial update, check bank 2 untouched
        for (int m = 1; m < 16; m++) begin
            logic [19:0] a;
            a = {1'b0, 15'h7FFF, 4'(m)};
            do_write(a, ~(32'h1234_5678 + 32'(m)), 4'hF);
            do_write(a, 32'h0BAD_F00D ^ 32'(m << 8), 4'(m));
            do_read(a, 4'hF);
            do_read({1'b1, a[18:0]}, 4'hF);
        end
        busy_probe();
        do_read(20'h00007, 4'hF);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule